// File: doc/BRIEF.md
# Two-Channel Serial Interrupt Vector Logic

This block keeps the interrupt bookkeeping for a pair of serial channels, called A and B. Each channel reports four kinds of event: a character has arrived, the transmitter has finished a byte, the host has written a transmit byte, and the host has read a received byte. Each channel also supplies a break status level. From these the block tracks, per channel, receive-pending, transmit-pending and two under-service latches. It produces one combined interrupt request, a pending-bits byte and an interrupt vector byte.

Receive has priority over transmit. When a receive is under service on a channel, a later transmit completion on that channel is recorded but does not take the vector. The transmit is posted later, when the receive is released. The host releases interrupts with two commands, each aimed at one channel: reset the highest under-service latch, and reset transmit-pending. The vector register stores which source it names, and the output byte is encoded from that source using the live status-high select.

Top module: `serial_irq_vec`

## Requirements
- R1: Channel c requests an interrupt when any of these holds: `tx_ien[c]` is set and transmit is pending; `rx_mode[c]` is 2'b01 or 2'b10 and receive is pending; or `brk_ien[c]` and `brk[c]` are both set. `irq_o` is the OR of the two channel requests. Index 0 is channel A and index 1 is channel B.
- R2: `pend_o` is laid out as follows. Bit 5 is A receive-pending and bit 2 is B receive-pending. Bit 4 is A transmit-pending AND `tx_ien[0]`, and bit 1 is B transmit-pending AND `tx_ien[1]`. Bit 3 is A break AND enable, and bit 0 is B break AND enable. Bits 7:6 are 0.
- R3: With `hi_sel`=0, `vec_o` is 0x06 for no source, 0x0C for A receive, 0x04 for B receive, 0x08 for A transmit and 0x00 for B transmit.
- R4: With `hi_sel`=1, `vec_o` is 0x60 for no source, 0x30 for A receive, 0x20 for B receive, 0x10 for A transmit and 0x00 for B transmit. The select acts on the stored source at once, with no clock edge needed.
- R5: A receive event sets that channel's receive-pending and receive-under-service latches. The vector then names that channel's receive.
- R6: A transmit-done event sets transmit-pending. If no receive is under service on that channel, it also sets transmit-under-service and the vector names that channel's transmit. Otherwise the vector is left unchanged.
- R7: The command code 3'b111 (command byte bits 5:3) resets the highest under-service latch. If receive is under service, it is cleared, and a pending transmit is then posted: its latch is set and the vector names it. Otherwise the transmit-under-service latch is cleared.
- R8: The command code 3'b101 resets transmit-pending. It clears transmit-pending and transmit-under-service, and the vector becomes "none". A still-pending receive on that channel is then posted again.
- R9: A host transmit write clears transmit-pending. A host receive read clears receive-pending and receive-under-service, and the vector becomes "none". A pending transmit on that channel is then posted.
- R10: The actions of one clock cycle are applied in this order: the command, then host accesses for A and then B, then events for A and then B, with transmit-done before receive within a channel. The last action that touches the vector wins.
- R11: After reset nothing is pending, `irq_o` is 0 while the break inputs are low, and the vector names no source.
- R12: A command whose code is neither 3'b111 nor 3'b101, or one given with `cmd_we` low, changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hi_sel | input | 1 | Vector status-high select |
| tx_ien | input | 2 | Transmit interrupt enable per channel |
| rx_mode | input | 2x2 | Receive interrupt mode per channel (01 or 10 enable) |
| brk_ien | input | 2 | Break interrupt enable per channel |
| brk | input | 2 | Break status per channel |
| cmd_we | input | 1 | Command strobe |
| cmd_ch | input | 1 | Command target channel (0 = A, 1 = B) |
| cmd_code | input | 3 | Command code (bits 5:3 of the command byte) |
| tx_wr | input | 2 | Host wrote transmit byte, per channel |
| rx_rd | input | 2 | Host read received byte, per channel |
| tx_done | input | 2 | Transmitter finished a byte, per channel |
| rx_evt | input | 2 | Character received, per channel |
| irq_o | output | 1 | Combined interrupt request |
| pend_o | output | 8 | Pending-bits byte |
| vec_o | output | 8 | Interrupt vector byte |

## Verification
The block has no tunable sizes, so the bench builds it with its defaults: two channels and byte-wide status outputs. Every event, host access and command is reachable on both channels in the same cycle. This is what lets the random phase hit the R10 ordering cases, such as a channel A transmit overtaken by a channel B receive. The random phase also reaches deferred transmits that are reposted by a read or by the under-service reset. Directed steps pin the status-high vector codes and the break path.

// File: rtl/siv_pkg.sv
package siv_pkg;
    localparam int NCH    = 2;
    localparam int REG_W  = 8;
    localparam int CODE_W = 3;

    localparam logic [CODE_W-1:0] CMD_RST_IUS = 3'b111;
    localparam logic [CODE_W-1:0] CMD_RST_TXP = 3'b101;

    typedef enum logic [2:0] {
        VK_NONE = 3'd0,
        VK_RXA  = 3'd1,
        VK_RXB  = 3'd2,
        VK_TXA  = 3'd3,
        VK_TXB  = 3'd4
    } vkind_e;

    typedef struct packed {
        logic [NCH-1:0] rxp;
        logic [NCH-1:0] txp;
        logic [NCH-1:0] rius;
        logic [NCH-1:0] tius;
        vkind_e         vk;
    } siv_state_t;

    function automatic vkind_e rx_kind(input int ch);
        return (ch == 0) ? VK_RXA : VK_RXB;
    endfunction

    function automatic vkind_e tx_kind(input int ch);
        return (ch == 0) ? VK_TXA : VK_TXB;
    endfunction

    function automatic logic [REG_W-1:0] vec_code(input vkind_e k, input logic hi);
        logic [REG_W-1:0] v;
        case (k)
            VK_RXA:  v = hi ? 8'h30 : 8'h0C;
            VK_RXB:  v = hi ? 8'h20 : 8'h04;
            VK_TXA:  v = hi ? 8'h10 : 8'h08;
            VK_TXB:  v = 8'h00;
            default: v = hi ? 8'h60 : 8'h06;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/siv_req_eval.sv
module siv_req_eval (
    input  logic       tx_ien,
    input  logic [1:0] rx_mode,
    input  logic       brk_ien,
    input  logic       brk,
    input  logic       rxp,
    input  logic       txp,
    output logic       req,
    output logic [2:0] pbits
);
    logic rx_on;
    logic tx_src;
    logic rx_src;
    logic ex_src;

    always_comb begin
        rx_on  = (rx_mode == 2'b01) || (rx_mode == 2'b10);
        tx_src = tx_ien & txp;
        rx_src = rx_on & rxp;
        ex_src = brk_ien & brk;
        req    = tx_src | rx_src | ex_src;
        pbits  = {rxp, tx_src, ex_src};
    end
endmodule

// File: rtl/siv_cmd_dec.sv
module siv_cmd_dec
    import siv_pkg::*;
(
    input  logic              cmd_we,
    input  logic              cmd_ch,
    input  logic [CODE_W-1:0] cmd_code,
    output logic [NCH-1:0]    ius_rst,
    output logic [NCH-1:0]    txp_rst
);
    always_comb begin
        ius_rst = '0;
        txp_rst = '0;
        if (cmd_we) begin
            if (cmd_code == CMD_RST_IUS) ius_rst[cmd_ch] = 1'b1;
            if (cmd_code == CMD_RST_TXP) txp_rst[cmd_ch] = 1'b1;
        end
    end
endmodule

// File: rtl/serial_irq_vec.sv
module serial_irq_vec
    import siv_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      hi_sel,
    input  logic [NCH-1:0]            tx_ien,
    input  logic [NCH-1:0][1:0]       rx_mode,
    input  logic [NCH-1:0]            brk_ien,
    input  logic [NCH-1:0]            brk,
    input  logic                      cmd_we,
    input  logic                      cmd_ch,
    input  logic [CODE_W-1:0]         cmd_code,
    input  logic [NCH-1:0]            tx_wr,
    input  logic [NCH-1:0]            rx_rd,
    input  logic [NCH-1:0]            tx_done,
    input  logic [NCH-1:0]            rx_evt,
    output logic                      irq_o,
    output logic [REG_W-1:0]          pend_o,
    output logic [REG_W-1:0]          vec_o
);
    localparam int PB_W = 3;

    siv_state_t st_d, st_q;
    logic [NCH-1:0]          ius_rst;
    logic [NCH-1:0]          txp_rst;
    logic [NCH-1:0]          ch_req;
    logic [NCH-1:0][PB_W-1:0] ch_pb;

    siv_cmd_dec i_dec (
        .cmd_we   (cmd_we),
        .cmd_ch   (cmd_ch),
        .cmd_code (cmd_code),
        .ius_rst  (ius_rst),
        .txp_rst  (txp_rst)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        siv_req_eval i_req (
            .tx_ien  (tx_ien[g]),
            .rx_mode (rx_mode[g]),
            .brk_ien (brk_ien[g]),
            .brk     (brk[g]),
            .rxp     (st_q.rxp[g]),
            .txp     (st_q.txp[g]),
            .req     (ch_req[g]),
            .pbits   (ch_pb[g])
        );
    end

    always_comb begin
        st_d = st_q;
        // commands first
        for (int c = 0; c < NCH; c++) begin
            if (ius_rst[c]) begin
                if (st_d.rius[c]) begin
                    st_d.rius[c] = 1'b0;
                    if (st_d.txp[c]) begin
                        st_d.tius[c] = 1'b1;
                        st_d.vk      = tx_kind(c);
                    end
                end else begin
                    st_d.tius[c] = 1'b0;
                end
            end
            if (txp_rst[c]) begin
                st_d.txp[c]  = 1'b0;
                st_d.tius[c] = 1'b0;
                st_d.vk      = VK_NONE;
                if (st_d.rxp[c]) begin
                    st_d.rius[c] = 1'b1;
                    st_d.vk      = rx_kind(c);
                end
            end
        end
        // host accesses next
        for (int c = 0; c < NCH; c++) begin
            if (tx_wr[c]) st_d.txp[c] = 1'b0;
            if (rx_rd[c]) begin
                st_d.rxp[c]  = 1'b0;
                st_d.rius[c] = 1'b0;
                st_d.vk      = VK_NONE;
                if (st_d.txp[c]) begin
                    st_d.tius[c] = 1'b1;
                    st_d.vk      = tx_kind(c);
                end
            end
        end
        // channel events last
        for (int c = 0; c < NCH; c++) begin
            if (tx_done[c]) begin
                st_d.txp[c] = 1'b1;
                if (!st_d.rius[c]) begin
                    st_d.tius[c] = 1'b1;
                    st_d.vk      = tx_kind(c);
                end
            end
            if (rx_evt[c]) begin
                st_d.rxp[c]  = 1'b1;
                st_d.rius[c] = 1'b1;
                st_d.vk      = rx_kind(c);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{rxp: '0, txp: '0, rius: '0, tius: '0, vk: VK_NONE};
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o  = |ch_req;
    assign pend_o = {{(REG_W - 2*PB_W){1'b0}}, ch_pb[0], ch_pb[1]};
    assign vec_o  = vec_code(st_q.vk, hi_sel);

    // R10
    b_rx_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_evt[1] |=> (st_q.vk == VK_RXB));

    // R5
    a_rx_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_evt[0] && !rx_evt[1] && !tx_done[1]) |=> (st_q.vk == VK_RXA) && st_q.rius[0]);

    // R9
    tx_wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr[0] && !tx_done[0]) |=> !st_q.txp[0]);

    // R9
    rx_rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd[1] && !rx_evt[1]) |=> !st_q.rxp[1] && !st_q.rius[1]);

    // R8
    txp_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_code == CMD_RST_TXP && !tx_done[cmd_ch]) |=> !st_q.txp[$past(cmd_ch)]);

    // R1
    irq_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (pend_o != '0));

    // R6
    tx_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.rius[0] && tx_done[0] && !cmd_we && !rx_rd[0] && !rx_evt[0]
         && !rx_evt[1] && !tx_done[1] && !rx_rd[1])
        |=> $stable(st_q.vk));
endmodule

// File: tb/test_serial_irq_vec.sv
`timescale 1ns/1ps
module test_serial_irq_vec;
    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            hi_sel = 1'b0;
    logic [1:0]      tx_ien = '0;
    logic [1:0][1:0] rx_mode = '0;
    logic [1:0]      brk_ien = '0;
    logic [1:0]      brk = '0;
    logic            cmd_we = 1'b0;
    logic            cmd_ch = 1'b0;
    logic [2:0]      cmd_code = '0;
    logic [1:0]      tx_wr = '0;
    logic [1:0]      rx_rd = '0;
    logic [1:0]      tx_done = '0;
    logic [1:0]      rx_evt = '0;
    logic            irq_o;
    logic [7:0]      pend_o;
    logic [7:0]      vec_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // model state, index 0 = A; kind 0 none,1 rxA,2 rxB,3 txA,4 txB
    bit m_rxp[2], m_txp[2], m_rius[2], m_tius[2];
    int m_vk;

    always #2.5 clk = ~clk;

    serial_irq_vec i_serial_irq_vec (
        .clk(clk), .rst_n(rst_n), .hi_sel(hi_sel), .tx_ien(tx_ien),
        .rx_mode(rx_mode), .brk_ien(brk_ien), .brk(brk), .cmd_we(cmd_we),
        .cmd_ch(cmd_ch), .cmd_code(cmd_code), .tx_wr(tx_wr), .rx_rd(rx_rd),
        .tx_done(tx_done), .rx_evt(rx_evt), .irq_o(irq_o), .pend_o(pend_o),
        .vec_o(vec_o)
    );

    function automatic logic [7:0] exp_code(int k, bit hi);
        case (k)
            1: return hi ? 8'h30 : 8'h0C;
            2: return hi ? 8'h20 : 8'h04;
            3: return hi ? 8'h10 : 8'h08;
            4: return 8'h00;
            default: return hi ? 8'h60 : 8'h06;
        endcase
    endfunction

    function automatic logic [7:0] exp_pend();
        logic [7:0] p;
        p = '0;
        p[5] = m_rxp[0]; p[4] = m_txp[0] & tx_ien[0]; p[3] = brk_ien[0] & brk[0];
        p[2] = m_rxp[1]; p[1] = m_txp[1] & tx_ien[1]; p[0] = brk_ien[1] & brk[1];
        return p;
    endfunction

    function automatic logic exp_irq();
        logic r;
        r = 1'b0;
        for (int c = 0; c < 2; c++) begin
            r |= tx_ien[c] & m_txp[c];
            r |= ((rx_mode[c] == 2'b01) || (rx_mode[c] == 2'b10)) & m_rxp[c];
            r |= brk_ien[c] & brk[c];
        end
        return r;
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            m_rxp[c] = 0; m_txp[c] = 0; m_rius[c] = 0; m_tius[c] = 0;
        end
        m_vk = 0;
    endtask

    task automatic model_step();
        for (int c = 0; c < 2; c++) begin
            if (cmd_we && int'(cmd_ch) == c && cmd_code == 3'b111) begin
                if (m_rius[c]) begin
                    m_rius[c] = 0;
                    if (m_txp[c]) begin m_tius[c] = 1; m_vk = 3 + c; end
                end else m_tius[c] = 0;
            end
            if (cmd_we && int'(cmd_ch) == c && cmd_code == 3'b101) begin
                m_txp[c] = 0; m_tius[c] = 0; m_vk = 0;
                if (m_rxp[c]) begin m_rius[c] = 1; m_vk = 1 + c; end
            end
        end
        for (int c = 0; c < 2; c++) begin
            if (tx_wr[c]) m_txp[c] = 0;
            if (rx_rd[c]) begin
                m_rxp[c] = 0; m_rius[c] = 0; m_vk = 0;
                if (m_txp[c]) begin m_tius[c] = 1; m_vk = 3 + c; end
            end
        end
        for (int c = 0; c < 2; c++) begin
            if (tx_done[c]) begin
                m_txp[c] = 1;
                if (!m_rius[c]) begin m_tius[c] = 1; m_vk = 3 + c; end
            end
            if (rx_evt[c]) begin m_rxp[c] = 1; m_rius[c] = 1; m_vk = 1 + c; end
        end
    endtask

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_pulses();
        cmd_we = 0; tx_wr = '0; rx_rd = '0; tx_done = '0; rx_evt = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        clear_pulses();
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    initial begin
        #900000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hang expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        @(negedge clk);
        do_reset();
        // R11 reset state
        chk("R11 irq", {7'd0, irq_o}, 8'h00);
        chk("R11 pend", pend_o, 8'h00);
        chk("R11 vec", vec_o, 8'h06);

        tx_ien = 2'b11; rx_mode[0] = 2'b10; rx_mode[1] = 2'b01;
        rx_evt[1] = 1; tick();
        chk("R5 vec B rx", vec_o, 8'h04);
        chk("R5 pend B rx", pend_o, 8'h04);
        chk("R1 irq rx", {7'd0, irq_o}, 8'h01);
        tx_done[1] = 1; tick();
        chk("R6 deferred vec", vec_o, 8'h04);
        chk("R2 pend B rx tx", pend_o, 8'h06);
        hi_sel = 1; #1;
        chk("R4 hi B rx", vec_o, 8'h20);
        hi_sel = 0;
        cmd_we = 1; cmd_ch = 1; cmd_code = 3'b111; tick();
        chk("R7 repost tx B", vec_o, 8'h00);
        chk("R7 pend", pend_o, 8'h06);
        cmd_we = 1; cmd_ch = 1; cmd_code = 3'b101; tick();
        chk("R8 repost rx B", vec_o, 8'h04);
        chk("R8 pend", pend_o, 8'h04);
        rx_rd[1] = 1; tick();
        chk("R9 read vec", vec_o, 8'h06);
        chk("R9 read pend", pend_o, 8'h00);
        chk("R9 read irq", {7'd0, irq_o}, 8'h00);
        tx_done[0] = 1; rx_evt[1] = 1; tick();
        chk("R10 order vec", vec_o, 8'h04);
        chk("R10 order pend", pend_o, 8'h14);
        cmd_we = 1; cmd_ch = 1; cmd_code = 3'b010; tick();
        chk("R12 vec", vec_o, 8'h04);
        chk("R12 pend", pend_o, 8'h14);
        cmd_we = 0; cmd_ch = 1; cmd_code = 3'b101; #1; tick();
        chk("R12 no strobe", pend_o, 8'h14);
        tx_wr[0] = 1; tick();
        chk("R9 tx write", pend_o, 8'h04);
        brk_ien[1] = 1; brk[1] = 1; #1;
        chk("R1 break pend", pend_o, 8'h05);
        chk("R1 break irq", {7'd0, irq_o}, 8'h01);
        brk_ien = '0; brk = '0; rx_mode[1] = 2'b00; #1;
        chk("R1 rx mode off irq", {7'd0, irq_o}, 8'h00);
        chk("R2 rx bit raw", pend_o, 8'h04);
        rx_mode[1] = 2'b11; #1;
        chk("R1 rx mode 11 irq", {7'd0, irq_o}, 8'h00);
        rx_mode[1] = 2'b01;
        rx_rd[1] = 1; tick();
        hi_sel = 1; #1;
        chk("R4 hi none", vec_o, 8'h60);
        rx_evt[0] = 1; tick();
        chk("R4 hi A rx", vec_o, 8'h30);
        tx_done[0] = 1; tick();
        chk("R6 A deferred", vec_o, 8'h30);
        rx_rd[0] = 1; tick();
        chk("R4 hi A tx", vec_o, 8'h10);
        hi_sel = 0; #1;
        chk("R3 A tx", vec_o, 8'h08);
        tx_done[1] = 1; tick();
        chk("R3 B tx", vec_o, 8'h00);

        // random phase
        do_reset();
        model_reset();
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 16 == 0) hi_sel = $urandom % 2;
            if ($urandom % 32 == 0) begin
                tx_ien = 2'($urandom); rx_mode = 4'($urandom); brk_ien = 2'($urandom);
            end
            if ($urandom % 8 == 0) brk = 2'($urandom);
            cmd_we = ($urandom % 5 == 0);
            cmd_ch = 1'($urandom);
            cmd_code = ($urandom % 2) ? (($urandom % 2) ? 3'b111 : 3'b101) : 3'($urandom);
            for (int c = 0; c < 2; c++) begin
                tx_wr[c]   = ($urandom % 7 == 0);
                rx_rd[c]   = ($urandom % 6 == 0);
                tx_done[c] = ($urandom % 5 == 0);
                rx_evt[c]  = ($urandom % 6 == 0);
            end
            model_step();
            @(posedge clk);
            @(negedge clk);
            chk("R1 rnd irq", {7'd0, irq_o}, {7'd0, exp_irq()});
            chk("R2 rnd pend", pend_o, exp_pend());
            chk("R10 rnd vec", vec_o, exp_code(m_vk, hi_sel));
        end
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule